// File: doc/BRIEF.md
# Page Table Walker

The walker resolves one map miss. A start pulse hands it a virtual page number, whether the reference is made in user or monitor mode, whether it is a write, and the write data that is pending. It picks a table base from the mode and the page range and reads the first page table entry. It then follows private, shared or indirect entries through a shared-page table and a core status table until it reaches a core page number. On success it writes one map register. On any fault it stores a status word and the pending data to memory and raises a trap output.

Memory is reached through a request/acknowledge port. The port carries one word per transfer and allows any number of wait cycles. Permission decoding lives outside the block. The walker shows the current entry to an external checker and samples two results from it: a trap code and a write-copy flag. Each table address is the base plus an index, so no table needs any alignment.

Top module: `page_walker`

## Requirements
- R1: With `busy` low the walker accepts `start`. While a walk is in progress `start` is ignored. Each walk ends with exactly one single-cycle pulse, either `done` or `trap_valid`, and never both.
- R2: For a user reference with `{0,start_page} >= addr_limit`, the walker reads no table entry and traps with code octal 401000.
- R3: The first entry address is `user_base + page` for user references. For monitor pages at or above `MON_HI_FIRST` (default 384, octal 600) it is `mon_base + page`. For lower monitor pages it is `map_base + page`.
- R4: Entry type sits in bits [35:34]: 0 private, 1 shared, 2 indirect, 3 illegal. A private entry with a zero location field [33:30] takes its core page from the low bits. After a good core status check the walker writes `map_idx = {user, page}` and `map_wdata = {write_allowed, core_page}`, and pulses `done` in the same cycle.
- R5: For a shared entry the walker reads `spt_base + index`, where the index is the entry's low `SIDX_W` bits. A nonzero location field [33:30] in that word traps with octal 240000 at the first level, or octal 204000 when the entry was reached through an indirect pointer. Otherwise the walker uses the low bits as the core page.
- R6: An indirect entry carries a shared-table index in its low bits and a slot in the next `SLOT_W` bits. The shared word gives the core page of the next table, and its location field traps with octal 220000 (first level) or 202000 (second level). After a good core status check, the next entry is read at `{core_page, slot}`.
- R7: An indirect entry found at the third level traps with octal 201000.
- R8: The core status word for page c is at `cst_base + c`. If its bits [35:33] are zero (age below octal 100), the walker traps with a code chosen by bits [32:31]: 0 gives octal 100000, 1 gives 040000, 2 gives 020000, 3 gives 010000.
- R9: A write reference whose core status bit 26 (dirty) is clear writes the same word back with bit 26 set. A read reference, or a word that is already dirty, causes no write.
- R10: If the checker reports write-copy at any level of the walk, the map entry's write-allowed bit is 0. Otherwise it is 1.
- R11: A nonzero checker code traps with that code. If the entry is at level two or three, octal 200000 is ORed into the code.
- R12: On a trap the walker writes the status word `{code[17:0], user, write, 7'b0, page}` to `mon_base + STAT_OFF`. It then writes the pending data to the next address and pulses `trap_valid` with `trap_status` equal to the status word.
- R13: An illegal entry type traps with octal 401000. A private entry with a nonzero location field traps with octal 500000, ORed with octal 200000 beyond the first level.
- R14: A request keeps `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` steady until `mem_ack`, however many wait cycles occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (sampled when idle) |
| start_user | input | 1 | Reference made in user mode |
| start_write | input | 1 | Reference is a write |
| start_page | input | PAGE_W | Virtual page number |
| start_wdata | input | 36 | Pending write data, saved on a trap |
| user_base | input | ADDR_W | User table base |
| map_base | input | ADDR_W | Monitor table base, low pages |
| mon_base | input | ADDR_W | Monitor base, high pages and trap store |
| spt_base | input | ADDR_W | Shared-page table base |
| cst_base | input | ADDR_W | Core status table base |
| addr_limit | input | PAGE_W+1 | First illegal user page |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Request address |
| mem_wdata | output | 36 | Write data |
| mem_ack | input | 1 | Request completed |
| mem_rdata | input | 36 | Read data, valid with `mem_ack` |
| chk_pte | output | 36 | Entry under check |
| chk_code | input | 18 | Checker trap code, 0 when allowed |
| chk_wcopy | input | 1 | Checker write-copy flag |
| map_we | output | 1 | Map register write |
| map_idx | output | PAGE_W+1 | Map index {user, page} |
| map_wdata | output | CPN_W+1 | {write_allowed, core page} |
| done | output | 1 | Map loaded |
| trap_valid | output | 1 | Walk ended in a trap |
| trap_status | output | 36 | Stored status word |

## Verification
A wrong walk state shows up first on `mem_addr`: a bad base, index or level produces an off-table address within one request of the fault. A wrong level count or a mixed-up pointer kind only appears later, as a wrong trap code in the stored status word and on `trap_status`, at the end of the walk. A stale dirty or write-copy decision is visible only at the final core status write and in the write-allowed bit of the map data. For that reason every walk is checked against the complete log of memory writes as well as its final pulse.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int WORD_W    = 36;
  localparam int CODE_W    = 18;
  localparam int DIRTY_BIT = 26;

  localparam logic [1:0] PT_PRIV = 2'd0;
  localparam logic [1:0] PT_SHR  = 2'd1;
  localparam logic [1:0] PT_IND  = 2'd2;
  localparam logic [1:0] PT_BAD  = 2'd3;

  localparam logic [CODE_W-1:0] C_ALRV   = 18'o401000;
  localparam logic [CODE_W-1:0] C_XSIND  = 18'o201000;
  localparam logic [CODE_W-1:0] C_PNIC   = 18'o500000;
  localparam logic [CODE_W-1:0] C_DEEP   = 18'o200000;
  localparam logic [CODE_W-1:0] C_SHRNIC = 18'o240000;
  localparam logic [CODE_W-1:0] C_ISHNIC = 18'o204000;
  localparam logic [CODE_W-1:0] C_T2NIC  = 18'o220000;
  localparam logic [CODE_W-1:0] C_T3NIC  = 18'o202000;

  typedef enum logic [3:0] {
    S_IDLE, S_PTE, S_CHK, S_SPT, S_CST, S_DIRTY, S_MAP, S_TRAP, S_TR0, S_TR1
  } walk_st_t;
endpackage

// File: rtl/ptw_base_sel.sv
module ptw_base_sel #(
  parameter int PAGE_W       = 9,
  parameter int ADDR_W       = 18,
  parameter int MON_HI_FIRST = 384
) (
  input  logic              user,
  input  logic [PAGE_W-1:0] page,
  input  logic [PAGE_W:0]   limit,
  input  logic [ADDR_W-1:0] user_base,
  input  logic [ADDR_W-1:0] map_base,
  input  logic [ADDR_W-1:0] mon_base,
  output logic              over_limit,
  output logic [ADDR_W-1:0] pte_addr
);
  localparam logic [PAGE_W-1:0] HI_FIRST = PAGE_W'(MON_HI_FIRST);
  logic [ADDR_W-1:0] base;

  always_comb begin
    over_limit = user && ({1'b0, page} >= limit);
    if (user)                 base = user_base;
    else if (page >= HI_FIRST) base = mon_base;
    else                      base = map_base;
    pte_addr = base + ADDR_W'(page);
  end
endmodule

// File: rtl/ptw_cst_eval.sv
module ptw_cst_eval
  import ptw_pkg::*;
(
  input  logic [WORD_W-1:0] cst,
  input  logic              write_ref,
  output logic              absent,
  output logic [CODE_W-1:0] code,
  output logic              need_dirty,
  output logic [WORD_W-1:0] cst_new
);
  always_comb begin
    absent = (cst[35:33] == 3'd0);
    case (cst[32:31])
      2'd0:    code = 18'o100000;
      2'd1:    code = 18'o040000;
      2'd2:    code = 18'o020000;
      default: code = 18'o010000;
    endcase
    need_dirty = write_ref && !cst[DIRTY_BIT];
    cst_new    = cst | (WORD_W'(1) << DIRTY_BIT);
  end
endmodule

// File: rtl/ptw_nic_code.sv
module ptw_nic_code
  import ptw_pkg::*;
(
  input  logic              via_ptr,
  input  logic [1:0]        level,
  output logic [CODE_W-1:0] code
);
  always_comb begin
    if (via_ptr) code = (level == 2'd1) ? C_T2NIC : C_T3NIC;
    else         code = (level == 2'd1) ? C_SHRNIC : C_ISHNIC;
  end
endmodule

// File: rtl/page_walker.sv
module page_walker
  import ptw_pkg::*;
#(
  parameter int PAGE_W       = 9,
  parameter int CPN_W        = 9,
  parameter int SIDX_W       = 9,
  parameter int SLOT_W       = 9,
  parameter int ADDR_W       = 18,
  parameter int MON_HI_FIRST = 384,
  parameter int STAT_OFF     = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                start_user,
  input  logic                start_write,
  input  logic [PAGE_W-1:0]   start_page,
  input  logic [WORD_W-1:0]   start_wdata,
  input  logic [ADDR_W-1:0]   user_base,
  input  logic [ADDR_W-1:0]   map_base,
  input  logic [ADDR_W-1:0]   mon_base,
  input  logic [ADDR_W-1:0]   spt_base,
  input  logic [ADDR_W-1:0]   cst_base,
  input  logic [PAGE_W:0]     addr_limit,
  output logic                busy,
  output logic                mem_req,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [WORD_W-1:0]   mem_wdata,
  input  logic                mem_ack,
  input  logic [WORD_W-1:0]   mem_rdata,
  output logic [WORD_W-1:0]   chk_pte,
  input  logic [CODE_W-1:0]   chk_code,
  input  logic                chk_wcopy,
  output logic                map_we,
  output logic [PAGE_W:0]     map_idx,
  output logic [CPN_W:0]      map_wdata,
  output logic                done,
  output logic                trap_valid,
  output logic [WORD_W-1:0]   trap_status
);
  localparam int NEXT_W = CPN_W + SLOT_W;

  walk_st_t            st;
  logic [1:0]          level;
  logic [PAGE_W-1:0]   page_q;
  logic                user_q, wr_q, wcopy_q, via_ptr;
  logic [WORD_W-1:0]   wdata_q, pte_q, status_q;
  logic [CPN_W-1:0]    cpn_q;
  logic [SLOT_W-1:0]   slot_q;

  logic                over_limit;
  logic [ADDR_W-1:0]   first_addr;
  logic                cst_absent, cst_need_dirty;
  logic [CODE_W-1:0]   cst_code, nic_code, deep_bit;
  logic [WORD_W-1:0]   cst_new;

  ptw_base_sel #(.PAGE_W(PAGE_W), .ADDR_W(ADDR_W), .MON_HI_FIRST(MON_HI_FIRST)) u_base (
    .user(start_user), .page(start_page), .limit(addr_limit),
    .user_base(user_base), .map_base(map_base), .mon_base(mon_base),
    .over_limit(over_limit), .pte_addr(first_addr)
  );

  ptw_cst_eval u_cst (
    .cst(mem_rdata), .write_ref(wr_q), .absent(cst_absent), .code(cst_code),
    .need_dirty(cst_need_dirty), .cst_new(cst_new)
  );

  ptw_nic_code u_nic (.via_ptr(via_ptr), .level(level), .code(nic_code));

  assign deep_bit = (level != 2'd1) ? C_DEEP : '0;
  assign busy     = (st != S_IDLE);
  assign chk_pte  = pte_q;

  function automatic logic [WORD_W-1:0] mk_status(input logic [CODE_W-1:0] c,
      input logic u, input logic w, input logic [PAGE_W-1:0] p);
    logic [WORD_W-1:0] s;
    s = '0;
    s[WORD_W-1 -: CODE_W] = c;
    s[17] = u;
    s[16] = w;
    s[PAGE_W-1:0] = p;
    return s;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_IDLE;
      level       <= 2'd1;
      page_q      <= '0;
      user_q      <= 1'b0;
      wr_q        <= 1'b0;
      wcopy_q     <= 1'b0;
      via_ptr     <= 1'b0;
      wdata_q     <= '0;
      pte_q       <= '0;
      status_q    <= '0;
      cpn_q       <= '0;
      slot_q      <= '0;
      mem_req     <= 1'b0;
      mem_we      <= 1'b0;
      mem_addr    <= '0;
      mem_wdata   <= '0;
      map_we      <= 1'b0;
      map_idx     <= '0;
      map_wdata   <= '0;
      done        <= 1'b0;
      trap_valid  <= 1'b0;
      trap_status <= '0;
    end else begin
      done       <= 1'b0;
      trap_valid <= 1'b0;
      map_we     <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          page_q  <= start_page;
          user_q  <= start_user;
          wr_q    <= start_write;
          wdata_q <= start_wdata;
          level   <= 2'd1;
          wcopy_q <= 1'b0;
          via_ptr <= 1'b0;
          if (over_limit) begin
            status_q <= mk_status(C_ALRV, start_user, start_write, start_page);
            st       <= S_TRAP;
          end else begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= first_addr;
            st       <= S_PTE;
          end
        end
        S_PTE: if (mem_ack) begin
          pte_q   <= mem_rdata;
          mem_req <= 1'b0;
          st      <= S_CHK;
        end
        S_CHK: begin
          wcopy_q <= wcopy_q | chk_wcopy;
          if (pte_q[35:34] == PT_BAD) begin
            status_q <= mk_status(C_ALRV, user_q, wr_q, page_q);
            st       <= S_TRAP;
          end else if (chk_code != '0) begin
            status_q <= mk_status(chk_code | deep_bit, user_q, wr_q, page_q);
            st       <= S_TRAP;
          end else if (pte_q[35:34] == PT_PRIV) begin
            if (pte_q[33:30] != 4'd0) begin
              status_q <= mk_status(C_PNIC | deep_bit, user_q, wr_q, page_q);
              st       <= S_TRAP;
            end else begin
              via_ptr  <= 1'b0;
              cpn_q    <= pte_q[CPN_W-1:0];
              mem_req  <= 1'b1;
              mem_addr <= cst_base + ADDR_W'(pte_q[CPN_W-1:0]);
              st       <= S_CST;
            end
          end else if (pte_q[35:34] == PT_SHR) begin
            via_ptr  <= 1'b0;
            mem_req  <= 1'b1;
            mem_addr <= spt_base + ADDR_W'(pte_q[SIDX_W-1:0]);
            st       <= S_SPT;
          end else if (level == 2'd3) begin
            status_q <= mk_status(C_XSIND, user_q, wr_q, page_q);
            st       <= S_TRAP;
          end else begin
            via_ptr  <= 1'b1;
            slot_q   <= pte_q[SIDX_W +: SLOT_W];
            mem_req  <= 1'b1;
            mem_addr <= spt_base + ADDR_W'(pte_q[SIDX_W-1:0]);
            st       <= S_SPT;
          end
        end
        S_SPT: if (mem_ack) begin
          if (mem_rdata[33:30] != 4'd0) begin
            mem_req  <= 1'b0;
            status_q <= mk_status(nic_code, user_q, wr_q, page_q);
            st       <= S_TRAP;
          end else begin
            cpn_q    <= mem_rdata[CPN_W-1:0];
            mem_addr <= cst_base + ADDR_W'(mem_rdata[CPN_W-1:0]);
            st       <= S_CST;
          end
        end
        S_CST: if (mem_ack) begin
          if (cst_absent) begin
            mem_req  <= 1'b0;
            status_q <= mk_status(cst_code, user_q, wr_q, page_q);
            st       <= S_TRAP;
          end else if (via_ptr) begin
            level    <= level + 2'd1;
            mem_addr <= ADDR_W'(NEXT_W'({cpn_q, slot_q}));
            st       <= S_PTE;
          end else if (cst_need_dirty) begin
            mem_we    <= 1'b1;
            mem_wdata <= cst_new;
            st        <= S_DIRTY;
          end else begin
            mem_req <= 1'b0;
            st      <= S_MAP;
          end
        end
        S_DIRTY: if (mem_ack) begin
          mem_req <= 1'b0;
          mem_we  <= 1'b0;
          st      <= S_MAP;
        end
        S_MAP: begin
          map_we    <= 1'b1;
          map_idx   <= {user_q, page_q};
          map_wdata <= {~wcopy_q, cpn_q};
          done      <= 1'b1;
          st        <= S_IDLE;
        end
        S_TRAP: begin
          mem_req   <= 1'b1;
          mem_we    <= 1'b1;
          mem_addr  <= mon_base + ADDR_W'(STAT_OFF);
          mem_wdata <= status_q;
          st        <= S_TR0;
        end
        S_TR0: if (mem_ack) begin
          mem_addr  <= mem_addr + ADDR_W'(1);
          mem_wdata <= wdata_q;
          st        <= S_TR1;
        end
        S_TR1: if (mem_ack) begin
          mem_req     <= 1'b0;
          mem_we      <= 1'b0;
          trap_valid  <= 1'b1;
          trap_status <= status_q;
          st          <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_one_end_r1: assert property (@(posedge clk) disable iff (rst)
    !(done && trap_valid));

  p_limit_trap_r2: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE) && start && start_user && ({1'b0, start_page} >= addr_limit)
    |=> (st == S_TRAP) && (status_q[WORD_W-1 -: CODE_W] == C_ALRV));

  p_level_range_r7: assert property (@(posedge clk) disable iff (rst)
    (st != S_IDLE) |-> (level != 2'd0));

  p_dirty_write_r9: assert property (@(posedge clk) disable iff (rst)
    (st == S_DIRTY) |-> mem_req && mem_we && mem_wdata[DIRTY_BIT]);

  p_req_hold_r14: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                            && $stable(mem_wdata));
endmodule

// File: tb/tb_page_walker.sv
`timescale 1ns/1ps
module tb_page_walker;
  localparam int UB = 4096, MB = 8192, MON = 12288, SPT = 16384, CST = 20480;
  localparam int STAT_A = MON + 16;

  logic clk = 0, rst = 1;
  logic start = 0, start_user = 0, start_write = 0;
  logic [8:0] start_page = 0;
  logic [35:0] start_wdata = 0;
  logic busy, mem_req, mem_we, mem_ack = 0, map_we, done, trap_valid, chk_wcopy = 0;
  logic [17:0] mem_addr;
  logic [35:0] mem_wdata, mem_rdata = 0, chk_pte, trap_status;
  logic [17:0] chk_code, perm_cfg = 0;
  logic [9:0] map_idx;
  logic [9:0] map_wdata;

  always #2.5 clk = ~clk;
  assign chk_code = (chk_pte[35:34] == 2'b00) ? perm_cfg : 18'd0;

  page_walker dut (
    .clk(clk), .rst(rst), .start(start), .start_user(start_user), .start_write(start_write),
    .start_page(start_page), .start_wdata(start_wdata),
    .user_base(18'(UB)), .map_base(18'(MB)), .mon_base(18'(MON)),
    .spt_base(18'(SPT)), .cst_base(18'(CST)), .addr_limit(10'd256),
    .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .chk_pte(chk_pte), .chk_code(chk_code), .chk_wcopy(chk_wcopy),
    .map_we(map_we), .map_idx(map_idx), .map_wdata(map_wdata),
    .done(done), .trap_valid(trap_valid), .trap_status(trap_status)
  );

  int checks = 0, errs = 0;
  logic [35:0] mem [int];
  int wait_n = 1, cnt = 0, hold_err = 0, nreads = 0;
  logic [17:0] cur_a; logic cur_we;
  logic [17:0] wr_a [$];
  logic [35:0] wr_d [$];
  int ndone = 0, ntrap = 0, nmap = 0;
  bit got_done, got_trap;
  logic [9:0] idx_s, mdat_s;
  logic [35:0] tstat_s;

  function automatic logic [35:0] rd(input logic [17:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 36'd0;
  endfunction

  always @(negedge clk) begin
    if (rst) begin mem_ack = 0; cnt = 0; end
    else if (mem_ack) begin mem_ack = 0; cnt = 0; end
    else if (mem_req) begin
      if (cnt == 0) begin cur_a = mem_addr; cur_we = mem_we; end
      else if (mem_addr != cur_a || mem_we != cur_we) hold_err++;
      if (cnt >= wait_n) begin
        mem_ack = 1;
        if (mem_we) begin
          mem[int'(mem_addr)] = mem_wdata; wr_a.push_back(mem_addr); wr_d.push_back(mem_wdata);
        end else begin
          mem_rdata = rd(mem_addr); nreads++;
        end
      end else cnt++;
    end
    if (!rst) begin
      if (done) ndone++;
      if (trap_valid) ntrap++;
      if (map_we) nmap++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %o expected %o", req, what, act, exp);
    end
  endtask

  function automatic logic [35:0] priv(input int cpn, input int loc);
    return {2'b00, 4'(loc), 21'd0, 9'(cpn)};
  endfunction
  function automatic logic [35:0] shr(input int sidx);
    return {2'b01, 25'd0, 9'(sidx)};
  endfunction
  function automatic logic [35:0] ind(input int sidx, input int slot);
    return {2'b10, 16'd0, 9'(slot), 9'(sidx)};
  endfunction
  function automatic logic [35:0] cstw(input int state, input int why, input bit dirty);
    return {3'(state), 2'(why), 4'd0, dirty, 26'd0};
  endfunction
  function automatic logic [35:0] stat(input logic [17:0] c, input bit u, input bit w, input int p);
    return {c, u, w, 7'd0, 9'(p)};
  endfunction

  task automatic run(input bit u, input bit w, input int pg, input logic [35:0] wd, input int poke);
    wr_a.delete(); wr_d.delete();
    ndone = 0; ntrap = 0; nmap = 0; nreads = 0; hold_err = 0;
    got_done = 0; got_trap = 0;
    @(negedge clk);
    start = 1; start_user = u; start_write = w; start_page = 9'(pg); start_wdata = wd;
    @(negedge clk);
    start = 0;
    for (int k = 0; k < 3000; k++) begin
      if (k == poke) begin start = 1; start_user = ~u; start_page = 9'(pg) ^ 9'd1; end
      else start = 0;
      if (done) begin got_done = 1; idx_s = map_idx; mdat_s = map_wdata; end
      if (trap_valid) begin got_trap = 1; tstat_s = trap_status; end
      if (done || trap_valid) break;
      @(negedge clk);
    end
    start = 0;
    if (!got_done && !got_trap) chk(0, "R1", "walk end timeout", 0, 1);
    repeat (4) @(negedge clk);
  endtask

  task automatic expect_map(input string req, input int idx, input int data);
    chk(got_done && !got_trap, req, "done without trap", {got_trap, got_done}, 2'b01);
    chk(idx_s == 10'(idx), req, "map index", idx_s, idx);
    chk(mdat_s == 10'(data), req, "map data", mdat_s, data);
  endtask

  task automatic expect_trap(input string req, input logic [17:0] c, input bit u, input bit w,
                             input int pg, input logic [35:0] wd);
    logic [35:0] s;
    s = stat(c, u, w, pg);
    chk(got_trap && !got_done, req, "trap without done", {got_done, got_trap}, 2'b01);
    chk(tstat_s == s, req, "trap status", tstat_s, s);
    chk(wr_a.size() >= 2 && wr_a[wr_a.size()-2] == 18'(STAT_A) && wr_d[wr_d.size()-2] == s,
        "R12", "status store", wr_a.size() >= 2 ? wr_d[wr_d.size()-2] : 0, s);
    chk(wr_a.size() >= 1 && wr_a[wr_a.size()-1] == 18'(STAT_A + 1) && wr_d[wr_d.size()-1] == wd,
        "R12", "data store", wr_d.size() >= 1 ? wr_d[wr_d.size()-1] : 0, wd);
  endtask

  task automatic t_reset;
    chk(!busy && !done && !trap_valid && !mem_req && !map_we, "R1", "reset outputs",
        {busy, done, trap_valid, mem_req, map_we}, 0);
  endtask

  task automatic t_user_private;
    mem.delete(); mem[UB + 5] = priv(83, 0); mem[CST + 83] = cstw(4, 0, 0);
    run(1, 0, 5, 0, -1);
    expect_map("R4", {1'b1, 9'd5}, {1'b1, 9'd83});
    chk(wr_a.size() == 0, "R9", "no write on read ref", wr_a.size(), 0);
    chk(hold_err == 0, "R14", "request held", hold_err, 0);
  endtask

  task automatic t_mon_low_dirty;
    mem.delete(); mem[MB + 10] = priv(7, 0); mem[CST + 7] = cstw(2, 0, 0);
    run(0, 1, 10, 36'h5, -1);
    expect_map("R3", {1'b0, 9'd10}, {1'b1, 9'd7});
    chk(wr_a.size() == 1 && wr_a[0] == 18'(CST + 7) && wr_d[0] == cstw(2, 0, 1), "R9",
        "dirty set", wr_a.size() ? wr_d[0] : 0, cstw(2, 0, 1));
  endtask

  task automatic t_mon_high;
    mem.delete(); mem[MON + 400] = priv(9, 0); mem[CST + 9] = cstw(7, 0, 1);
    wait_n = 5;
    run(0, 1, 400, 0, -1);
    wait_n = 1;
    expect_map("R3", {1'b0, 9'd400}, {1'b1, 9'd9});
    chk(wr_a.size() == 0, "R9", "already dirty no write", wr_a.size(), 0);
    chk(hold_err == 0, "R14", "held over 5 waits", hold_err, 0);
  endtask

  task automatic t_limit;
    mem.delete();
    run(1, 1, 300, 36'o123456, -1);
    expect_trap("R2", 18'o401000, 1, 1, 300, 36'o123456);
    chk(nreads == 0, "R2", "no table read", nreads, 0);
  endtask

  task automatic t_shared;
    mem.delete(); mem[UB + 6] = shr(20); mem[SPT + 20] = priv(50, 0); mem[CST + 50] = cstw(1, 0, 0);
    wait_n = 0;
    run(1, 0, 6, 0, -1);
    wait_n = 1;
    expect_map("R5", {1'b1, 9'd6}, {1'b1, 9'd50});
    mem.delete(); mem[UB + 6] = shr(20); mem[SPT + 20] = priv(50, 3);
    run(1, 0, 6, 36'd77, -1);
    expect_trap("R5", 18'o240000, 1, 0, 6, 36'd77);
  endtask

  task automatic t_indirect;
    mem.delete();
    mem[UB + 7] = ind(30, 11); mem[SPT + 30] = priv(60, 0); mem[CST + 60] = cstw(2, 0, 0);
    mem[60 * 512 + 11] = priv(70, 0); mem[CST + 70] = cstw(3, 0, 0);
    wait_n = 3;
    run(1, 0, 7, 0, 2);
    wait_n = 1;
    expect_map("R6", {1'b1, 9'd7}, {1'b1, 9'd70});
    chk(ndone == 1 && nmap == 1, "R1", "start while busy ignored", {ndone, nmap}, 2);
    mem[CST + 60] = cstw(0, 2, 0);
    run(1, 0, 7, 36'd1, -1);
    expect_trap("R8", 18'o020000, 1, 0, 7, 36'd1);
    mem[CST + 60] = cstw(2, 0, 0); mem[SPT + 30] = priv(60, 1);
    run(1, 0, 7, 36'd2, -1);
    expect_trap("R6", 18'o220000, 1, 0, 7, 36'd2);
    mem[SPT + 30] = priv(60, 0); mem[60 * 512 + 11] = shr(31); mem[SPT + 31] = priv(5, 2);
    run(1, 0, 7, 36'd3, -1);
    expect_trap("R5", 18'o204000, 1, 0, 7, 36'd3);
  endtask

  task automatic t_cst_codes;
    logic [17:0] exp_c [4] = '{18'o100000, 18'o040000, 18'o020000, 18'o010000};
    for (int r = 0; r < 4; r++) begin
      mem.delete(); mem[UB + 2] = priv(40, 0); mem[CST + 40] = cstw(0, r, 0);
      run(1, 1, 2, 36'(r), -1);
      expect_trap("R8", exp_c[r], 1, 1, 2, 36'(r));
    end
  endtask

  task automatic t_depth;
    mem.delete();
    mem[UB + 3] = ind(1, 4); mem[SPT + 1] = priv(20, 0); mem[CST + 20] = cstw(4, 0, 0);
    mem[20 * 512 + 4] = ind(2, 5); mem[SPT + 2] = priv(21, 0); mem[CST + 21] = cstw(4, 0, 0);
    mem[21 * 512 + 5] = ind(3, 6);
    run(1, 0, 3, 36'd9, -1);
    expect_trap("R7", 18'o201000, 1, 0, 3, 36'd9);
    mem[SPT + 2] = priv(21, 5);
    run(1, 0, 3, 36'd8, -1);
    expect_trap("R6", 18'o202000, 1, 0, 3, 36'd8);
  endtask

  task automatic t_wcopy;
    mem.delete(); mem[UB + 5] = priv(83, 0); mem[CST + 83] = cstw(4, 0, 1);
    chk_wcopy = 1;
    run(1, 1, 5, 0, -1);
    chk_wcopy = 0;
    expect_map("R10", {1'b1, 9'd5}, {1'b0, 9'd83});
  endtask

  task automatic t_perm;
    mem.delete(); mem[UB + 5] = priv(83, 0); mem[CST + 83] = cstw(4, 0, 0);
    perm_cfg = 18'o404000;
    run(1, 0, 5, 36'd4, -1);
    expect_trap("R11", 18'o404000, 1, 0, 5, 36'd4);
    mem.delete();
    mem[UB + 7] = ind(30, 11); mem[SPT + 30] = priv(60, 0); mem[CST + 60] = cstw(2, 0, 0);
    mem[60 * 512 + 11] = priv(70, 0);
    run(1, 0, 7, 36'd6, -1);
    perm_cfg = 0;
    expect_trap("R11", 18'o604000, 1, 0, 7, 36'd6);
  endtask

  task automatic t_bad;
    mem.delete(); mem[MB + 1] = {2'b11, 34'd0};
    run(0, 0, 1, 36'd5, -1);
    expect_trap("R13", 18'o401000, 0, 0, 1, 36'd5);
    mem[MB + 1] = priv(12, 8);
    run(0, 0, 1, 36'd6, -1);
    expect_trap("R13", 18'o500000, 0, 0, 1, 36'd6);
  endtask

  initial begin
    #(200000 * 5);
    errs++; checks++;
    $display("FAIL R1 watchdog expired: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst = 0;
    @(negedge clk);
    t_user_private();
    t_mon_low_dirty();
    t_mon_high();
    t_limit();
    t_shared();
    t_indirect();
    t_cst_codes();
    t_depth();
    t_wcopy();
    t_perm();
    t_bad();
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule